// File: doc/BRIEF.md
# Indirection-Based Keystream Generator Core

This block produces a stream of 32-bit pseudo-random words from a 256-word state table, a running accumulator and the previous output word. Each step reads the state word at the step index. It stirs the accumulator with a rotated copy of itself and with the state word half a table away. It writes a fresh state word at the index, built from a lookup addressed by data, and then makes the output word from a second lookup addressed by data. A full pass runs 256 steps, one every four clock cycles.

Software or a key schedule fills the state table and the two registers through the load port while the core is idle. A start strobe then launches a pass. Every step produces one output word with a one-cycle valid pulse and its index. When the pass finishes, a done flag is raised. The accumulator, the previous output and the table are kept, so another start continues the same stream.

Top module: `ksg_core`

## Requirements
- R1: While reset is asserted, and after it is released, busy, done and out_valid are low. Asserting reset during a pass aborts the pass.
- R2: When load_en is high and the core is idle, load_kind selects the target: 0 writes load_data into state word load_addr, 1 writes the accumulator, 2 writes the previous-result register, and 3 writes nothing. Loads made while busy have no effect on any later output.
- R3: A start pulse while idle begins a pass at index 0, sets busy and clears done on the next edge. A start pulse while busy is ignored.
- R4: For step i, x takes state word i, and then the accumulator becomes ((a << 19) XOR (a >> 13)) + state[(i+128) mod 256], using 32-bit arithmetic that wraps.
- R5: The new state word is y = state[x mod 256] + a + b, where the lookup sees the value from before this step's write. y is stored to state word i.
- R6: The output word is b = state[(y >> 8) mod 256] + x. When that index equals i, the lookup returns the y just written. b is stored as result word i and is carried into the next step.
- R7: out_valid is a single-cycle pulse with out_index = i and out_word = result word i. It is high in the cycle after the fourth rising edge following the edge that accepts start, then every four cycles, with indices 0 to 255 in order.
- R8: On the edge that raises the pulse for index 255, busy falls and done rises. done stays high until the next accepted start.
- R9: The final accumulator, previous result and state table of one pass are the starting values of the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load strobe, honoured only when idle |
| load_kind | input | 2 | Load target: 0 state word, 1 accumulator, 2 previous result, 3 none |
| load_addr | input | 8 | State word index for load_kind 0 |
| load_data | input | 32 | Load value |
| start | input | 1 | Begin a 256-step pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| out_valid | output | 1 | One-cycle pulse per step |
| out_index | output | 8 | Step index of the presented word |
| out_word | output | 32 | Output word of that step |

## Verification
The first output word is due in the cycle after the fourth rising edge that follows the edge accepting start. Every later word follows exactly four cycles after the one before it. The bench drives inputs and samples outputs on falling edges and counts those falling edges between pulses, so it expects five for the first word and four for each one after. Each word is compared against a sequential software model that the bench runs on the same seed. The done and busy changes are checked on the same falling edge as the pulse for index 255. Stray start and load strobes are driven in the cycle that follows a pulse, and the words after them must still match the unchanged model.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_MIX   = 2'd1,
    PH_MERGE = 2'd2,
    PH_EMIT  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LD_STATE = 2'd0,
    LD_ACC   = 2'd1,
    LD_PREV  = 2'd2,
    LD_NONE  = 2'd3
  } load_kind_e;
endpackage

// File: rtl/ksg_ram.sv
module ksg_ram #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ksg_ctrl.sv
module ksg_ctrl
  import ksg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] oidx_q, oidx_d;

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    vld_d   = 1'b0;
    oidx_d  = oidx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        done_d  = 1'b0;
        phase_d = PH_FETCH;
        idx_d   = '0;
      end
    end else begin
      unique case (phase_q)
        PH_FETCH: phase_d = PH_MIX;
        PH_MIX:   phase_d = PH_MERGE;
        PH_MERGE: phase_d = PH_EMIT;
        default:  phase_d = PH_FETCH;
      endcase
      if (phase_q == PH_EMIT) begin
        vld_d  = 1'b1;
        oidx_d = idx_q;
        idx_d  = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= PH_FETCH;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      oidx_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
      oidx_q  <= oidx_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign phase     = phase_q;
  assign idx       = idx_q;
  assign out_valid = vld_q;
  assign out_index = oidx_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R7
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(busy_q));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R3
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/ksg_datapath.sv
module ksg_datapath
  import ksg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int ROT_L  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  phase_e            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              ld_acc,
  input  logic              ld_prev,
  input  logic [WORD_W-1:0] ld_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              res_en,
  output logic [WORD_W-1:0] res_data
);
  localparam int ROT_R = WORD_W - ROT_L;
  localparam logic [IDX_W-1:0] HALF_IDX = {1'b1, {(IDX_W-1){1'b0}}};

  function automatic logic [WORD_W-1:0] stir(input logic [WORD_W-1:0] v);
    return (v << ROT_L) ^ (v >> ROT_R);
  endfunction

  logic [WORD_W-1:0] x_q, x_d;
  logic [WORD_W-1:0] a_q, a_d;
  logic [WORD_W-1:0] y_q, y_d;
  logic [WORD_W-1:0] b_q, b_d;
  logic [WORD_W-1:0] look_val;
  logic [WORD_W-1:0] y_part;

  always_comb begin
    unique case (phase)
      PH_FETCH: rd_addr = idx;
      PH_MIX:   rd_addr = idx + HALF_IDX;
      PH_MERGE: rd_addr = x_q[IDX_W-1:0];
      default:  rd_addr = y_q[2*IDX_W-1:IDX_W];
    endcase
  end

  assign look_val = (phase == PH_EMIT && rd_addr == idx) ? y_q : rd_data;
  assign y_part   = rd_data + a_q;
  assign res_data = look_val + x_q;
  assign wr_en    = busy && (phase == PH_EMIT);
  assign res_en   = wr_en;
  assign wr_data  = y_q;

  always_comb begin
    x_d = x_q;
    a_d = a_q;
    y_d = y_q;
    b_d = b_q;
    if (busy) begin
      unique case (phase)
        PH_FETCH: x_d = rd_data;
        PH_MIX:   a_d = stir(a_q) + rd_data;
        PH_MERGE: y_d = y_part + b_q;
        default:  b_d = res_data;
      endcase
    end else begin
      if (ld_acc)  a_d = ld_data;
      if (ld_prev) b_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      a_q <= '0;
      y_q <= '0;
      b_q <= '0;
    end else begin
      x_q <= x_d;
      a_q <= a_d;
      y_q <= y_d;
      b_q <= b_d;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_acc) |=> $stable(a_q));
endmodule

// File: rtl/ksg_core.sv
module ksg_core
  import ksg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int ROT_L  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [1:0]        load_kind,
  input  logic [IDX_W-1:0]  load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_index,
  output logic [WORD_W-1:0] out_word
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  st_raddr;
  logic [WORD_W-1:0] st_rdata;
  logic              dp_wr;
  logic [WORD_W-1:0] dp_wdata;
  logic              res_en;
  logic [WORD_W-1:0] res_data;
  logic              ld_ok;
  logic              st_we;
  logic [IDX_W-1:0]  st_waddr;
  logic [WORD_W-1:0] st_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  assign ld_ok    = load_en && !busy;
  assign st_we    = busy ? dp_wr : (ld_ok && load_kind == LD_STATE);
  assign st_waddr = busy ? idx : load_addr;
  assign st_wdata = busy ? dp_wdata : load_data;

  ksg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .phase     (phase),
    .idx       (idx),
    .out_valid (out_valid),
    .out_index (out_index)
  );

  ksg_datapath #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ROT_L(ROT_L)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .busy     (busy),
    .phase    (phase),
    .idx      (idx),
    .rd_data  (st_rdata),
    .ld_acc   (ld_ok && load_kind == LD_ACC),
    .ld_prev  (ld_ok && load_kind == LD_PREV),
    .ld_data  (load_data),
    .rd_addr  (st_raddr),
    .wr_en    (dp_wr),
    .wr_data  (dp_wdata),
    .res_en   (res_en),
    .res_data (res_data)
  );

  ksg_ram #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_state (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  ksg_ram #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_result (
    .clk   (clk),
    .we    (res_en),
    .waddr (idx),
    .wdata (res_data),
    .raddr (out_index),
    .rdata (out_word)
  );

  // R5
  write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    dp_wr |-> (phase == PH_EMIT));
endmodule

// File: tb/ksg_core_bench.sv
module ksg_core_bench;
  logic        clk;
  logic        rst_n;
  logic        load_en;
  logic [1:0]  load_kind;
  logic [7:0]  load_addr;
  logic [31:0] load_data;
  logic        start;
  logic        busy;
  logic        done;
  logic        out_valid;
  logic [7:0]  out_index;
  logic [31:0] out_word;

  int checks = 0;
  int errors = 0;

  logic [31:0] mm [256];
  logic [31:0] exp_r [256];
  logic [31:0] a_m, b_m;

  // seed table: mode 0 constant, 1 scaled index, 2 linear congruential
  localparam int VEC_N = 4;
  localparam int          V_MODE [VEC_N] = '{0, 1, 2, 2};
  localparam logic [31:0] V_P    [VEC_N] = '{32'h0000_0010, 32'h9E37_79B9, 32'h00C0_FFEE, 32'h1357_2468};
  localparam logic [31:0] V_A    [VEC_N] = '{32'h0, 32'h0123_4567, 32'hFFFF_FFFF, 32'h8000_0000};
  localparam logic [31:0] V_B    [VEC_N] = '{32'h0, 32'h89AB_CDEF, 32'hFFFF_FFFF, 32'h0};

  ksg_core u_ksg_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_kind (load_kind),
    .load_addr (load_addr),
    .load_data (load_data),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_word  (out_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic model_pass();
    logic [31:0] x, y;
    for (int i = 0; i < 256; i++) begin
      x   = mm[i];
      a_m = ((a_m << 19) ^ (a_m >> 13)) + mm[(i + 128) % 256];
      y   = mm[x[7:0]] + a_m + b_m;
      mm[i] = y;
      b_m = mm[y[15:8]] + x;
      exp_r[i] = b_m;
    end
  endtask

  task automatic load_one(input logic [1:0] kind, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    load_en = 1'b1; load_kind = kind; load_addr = addr; load_data = data;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic seed_from(input int v);
    logic [31:0] s;
    s = V_P[v];
    for (int j = 0; j < 256; j++) begin
      if (V_MODE[v] == 0) mm[j] = V_P[v];
      else if (V_MODE[v] == 1) mm[j] = (V_P[v] * j) ^ (j << 24);
      else begin s = s * 32'd1664525 + 32'd1013904223; mm[j] = s; end
    end
    for (int j = 0; j < 256; j++) load_one(2'd0, j[7:0], mm[j]);
    load_one(2'd1, 8'd0, V_A[v]);
    load_one(2'd2, 8'd0, V_B[v]);
    a_m = V_A[v];
    b_m = V_B[v];
  endtask

  // poke kinds: 1 start, 2 state load, 3 accumulator load, all while busy
  task automatic run_pass(input int poke_at, input int poke_kind);
    int gap;
    model_pass();
    @(negedge clk);
    start = 1'b1;
    gap = 0;
    for (int k = 0; k < 256; k++) begin
      do begin
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        gap++;
        if (k == 0 && gap == 1)
          chk(busy && !done, "R3 start accepted", {30'd0, busy, done}, 32'h2);
      end while (!out_valid && gap < 20);
      chk(gap == ((k == 0) ? 5 : 4), "R7 pulse spacing", gap, (k == 0) ? 5 : 4);
      chk(out_index == k[7:0], "R7 index order", {24'd0, out_index}, k);
      chk(out_word == exp_r[k], "R4 R5 R6 R9 output word", out_word, exp_r[k]);
      if (k == 255)
        chk(done && !busy, "R8 done at last word", {30'd0, busy, done}, 32'h1);
      if (k == poke_at) begin
        if (poke_kind == 1) start = 1'b1;
        else if (poke_kind == 2) begin
          load_en = 1'b1; load_kind = 2'd0; load_addr = 8'hFF; load_data = 32'hDEAD_BEEF;
        end else if (poke_kind == 3) begin
          load_en = 1'b1; load_kind = 2'd1; load_addr = 8'h00; load_data = 32'h1234_5678;
        end
      end
      gap = 0;
    end
    @(negedge clk);
    start = 1'b0; load_en = 1'b0;
    chk(!out_valid, "R7 single pulse", {31'd0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_kind = 2'd0; load_addr = 8'd0; load_data = 32'd0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 outputs in reset", {29'd0, busy, done, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 outputs after reset", {29'd0, busy, done, out_valid}, 32'h0);

    // R2 R4 R5 R6 R9: vector table, two passes each
    for (int v = 0; v < VEC_N; v++) begin
      seed_from(v);
      run_pass(-1, 0);
      repeat (3) @(negedge clk);
      chk(done && !busy, "R8 done holds", {30'd0, busy, done}, 32'h1);
      run_pass(-1, 0);
    end

    // R3: start while busy ignored
    run_pass(10, 1);
    // R2: loads while busy ignored
    run_pass(20, 2);
    run_pass(30, 3);

    // R1: reset during a pass aborts it
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 reset aborts pass", {29'd0, busy, done, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !out_valid, "R1 idle after abort", {30'd0, busy, out_valid}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule